// File: doc/BRIEF.md
# Timer Channel with Selectable Counter Clear

A 16-bit up-counting timer channel with four general registers (slots A to D). Each slot works either as a compare register or as an input-capture register. A compare match happens when the counter already holds the slot value as an enabled count tick arrives. A capture happens when the slot's capture input pulses in capture mode, and it latches the present counter value into the slot. A 3-bit clear-select field in the control register picks which slot's event, if any, zeroes the counter. Two codes make the channel follow a clear that comes from another channel in a synchronized group.

The clear logic is a small state machine. Its state is derived from the registered control value and takes effect one clock after the control write. The states are: `CS_OFF` (no clearing), `CS_OWN` (the selected slot's event clears the counter), `CS_FOLLOW` (the external synchronous clear input zeroes the counter) and `CS_MUTED` (slot C or D is selected but works as a buffer, so it never clears). On every clock the machine re-decodes the control field. The transitions are: into `CS_OWN` for codes 001, 010, and for 101 or 110 when the selected slot is not buffered. Into `CS_MUTED` for 101 or 110 when it is buffered. Into `CS_FOLLOW` for 011 or 111 when sync is enabled. Into `CS_OFF` in every other case. When the channel clears itself it raises a one-clock `clr_out` pulse, which other channels of the group can use as their synchronous clear. A reduced build (`FULL_CLR=0`) has no bit 7 in the field.

Top module: `tmr_clrsel_chan`

## Requirements
- R1: After reset, `count` is 0, `ctl_q` is 0 (clear code 000), `cmp_hit`, `cap_hit` and `clr_out` are 0, and every slot reads 16'hFFFF.
- R2: With clear code 000 or 100 (control bits [7:5]), the counter keeps incrementing past a matching slot value. The match still raises the slot's `cmp_hit` bit one clock later, and `clr_out` stays 0.
- R3: With code 001 (slot A, write address 0) or 010 (slot B, address 1) and the slot in compare mode, an enabled tick that finds `count` equal to the slot value loads 0 instead of count+1. In the following cycle `clr_out` is 1 for one clock, and it is set only when `count` is 0.
- R4: Codes 101 (slot C, address 2) and 110 (slot D, address 3) clear the counter on that slot's match in the same way as R3.
- R5: A slot whose capture-mode bit is set (register at address 6, bit i for slot i) latches `count` when `cap_in[i]` is 1, and it raises `cap_hit[i]` the next cycle. If that slot is the selected clear source, the counter goes to 0 at the same edge and `clr_out` pulses.
- R6: When control bit 3 (slot C as buffer) or bit 2 (slot D as buffer) is set, that slot produces no match and no capture: no `cmp_hit`/`cap_hit` bit, no clear, and its value is kept.
- R7: With code 011 or 111 and sync-enable (control bit 4) set, a 1 on `sync_clr_in` zeroes the counter at that edge, and `clr_out` stays 0.
- R8: `sync_clr_in` has no effect when sync-enable is 0 or the code is anything other than 011 or 111.
- R9: With `FULL_CLR=0`, control bit 7 always reads 0 and writes to it are ignored, so a written code 101 acts as 001.
- R10: The counter advances and compares only when `cnt_en` and `tick` are both 1. With `cnt_en` low the counter holds its value and no match occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Counting enable |
| tick | input | 1 | Prescaled count tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | 0-3 slots A-D, 4 control, 5 counter, 6 capture-mode |
| wr_data | input | 16 | Write data |
| cap_in | input | 4 | Capture pulse per slot |
| sync_clr_in | input | 1 | Clear from another synchronized channel |
| count | output | 16 | Counter value |
| cmp_hit | output | 4 | Compare-match flags, one clock |
| cap_hit | output | 4 | Capture flags, one clock |
| clr_out | output | 1 | Pulse when this channel cleared itself |
| ctl_q | output | 8 | Control register readback |
| gr_flat | output | 64 | Slot values, slot i at bits [16i+15:16i] |

## Verification
The hardest situation to reach is a clear that coincides with another event on the same edge. One case is a capture into the selected slot, where the old count must land in the slot while the counter drops to 0. The other is a match that is blocked because the slot is a buffer. The stimulus writes the counter to a known value, sets the capture and buffer bits, and then pulses `cap_in` on a tick cycle. A second, reduced instance shares every input, so a code written with bit 7 set lets the two instances diverge visibly at their `count` and `ctl_q` ports.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NUM_GR = 4;

    typedef enum logic [1:0] {
        CS_OFF,
        CS_OWN,
        CS_FOLLOW,
        CS_MUTED
    } clr_state_e;

    localparam logic [2:0] CODE_NONE   = 3'b000;
    localparam logic [2:0] CODE_A      = 3'b001;
    localparam logic [2:0] CODE_B      = 3'b010;
    localparam logic [2:0] CODE_SYNC_L = 3'b011;
    localparam logic [2:0] CODE_NONE_H = 3'b100;
    localparam logic [2:0] CODE_C      = 3'b101;
    localparam logic [2:0] CODE_D      = 3'b110;
    localparam logic [2:0] CODE_SYNC_H = 3'b111;

    function automatic logic [1:0] src_index(input logic [2:0] code);
        logic [1:0] idx;
        unique case (code)
            CODE_B:  idx = 2'd1;
            CODE_C:  idx = 2'd2;
            CODE_D:  idx = 2'd3;
            default: idx = 2'd0;
        endcase
        return idx;
    endfunction
endpackage

// File: rtl/tmr_gr_slot.sv
module tmr_gr_slot #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] count,
    input  logic             adv,
    input  logic             cap_mode,
    input  logic             inert,
    input  logic             cap_in,
    output logic [CNT_W-1:0] value,
    output logic             cmp_ev,
    output logic             cap_ev
);
    always_comb begin
        cmp_ev = adv && !cap_mode && !inert && (count == value);
        cap_ev = cap_in && cap_mode && !inert;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            value <= '1;
        else if (wr)
            value <= wr_data;
        else if (cap_ev)
            value <= count;
    end
endmodule

// File: rtl/tmr_clr_fsm.sv
module tmr_clr_fsm
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        code,
    input  logic              sync_en,
    input  logic              buf_c,
    input  logic              buf_d,
    input  logic [NUM_GR-1:0] ev,
    input  logic              sync_clr_in,
    output logic              own_clr,
    output logic              follow_clr
);
    clr_state_e state, nxt;

    always_comb begin
        unique case (code)
            CODE_A, CODE_B:           nxt = CS_OWN;
            CODE_C:                   nxt = buf_c ? CS_MUTED : CS_OWN;
            CODE_D:                   nxt = buf_d ? CS_MUTED : CS_OWN;
            CODE_SYNC_L, CODE_SYNC_H: nxt = sync_en ? CS_FOLLOW : CS_OFF;
            default:                  nxt = CS_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= CS_OFF;
        else
            state <= nxt;
    end

    always_comb begin
        own_clr    = 1'b0;
        follow_clr = 1'b0;
        unique case (state)
            CS_OWN:    own_clr    = ev[src_index(code)];
            CS_FOLLOW: follow_clr = sync_clr_in;
            CS_MUTED:  own_clr    = 1'b0;
            default:   own_clr    = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr_clrsel_chan.sv
module tmr_clrsel_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter bit FULL_CLR = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cnt_en,
    input  logic                    tick,
    input  logic                    wr_en,
    input  logic [2:0]              wr_addr,
    input  logic [CNT_W-1:0]        wr_data,
    input  logic [NUM_GR-1:0]       cap_in,
    input  logic                    sync_clr_in,
    output logic [CNT_W-1:0]        count,
    output logic [NUM_GR-1:0]       cmp_hit,
    output logic [NUM_GR-1:0]       cap_hit,
    output logic                    clr_out,
    output logic [7:0]              ctl_q,
    output logic [NUM_GR*CNT_W-1:0] gr_flat
);
    localparam logic [2:0] ADDR_CTL  = 3'd4;
    localparam logic [2:0] ADDR_CNT  = 3'd5;
    localparam logic [2:0] ADDR_MODE = 3'd6;
    localparam logic [7:0] CTL_MASK  = FULL_CLR ? 8'hFC : 8'h7C;

    logic [7:0]        ctl_r;
    logic [NUM_GR-1:0] mode_r;
    logic [NUM_GR-1:0] cmp_ev, cap_ev, ev;
    logic              adv, cnt_wr, own_clr, follow_clr;

    assign adv    = cnt_en && tick;
    assign cnt_wr = wr_en && (wr_addr == ADDR_CNT);
    assign ev     = cmp_ev | cap_ev;
    assign ctl_q  = ctl_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_r  <= '0;
            mode_r <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CTL)
                ctl_r <= wr_data[7:0] & CTL_MASK;
            if (wr_addr == ADDR_MODE)
                mode_r <= wr_data[NUM_GR-1:0];
        end
    end

    for (genvar i = 0; i < NUM_GR; i++) begin : g_slot
        localparam logic [2:0] SLOT_ADDR = 3'(i);
        logic inert;
        if (i == 2) begin : g_bc
            assign inert = ctl_r[3];
        end else if (i == 3) begin : g_bd
            assign inert = ctl_r[2];
        end else begin : g_nb
            assign inert = 1'b0;
        end
        tmr_gr_slot #(.CNT_W(CNT_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (wr_en && (wr_addr == SLOT_ADDR)),
            .wr_data (wr_data),
            .count   (count),
            .adv     (adv),
            .cap_mode(mode_r[i]),
            .inert   (inert),
            .cap_in  (cap_in[i]),
            .value   (gr_flat[i*CNT_W +: CNT_W]),
            .cmp_ev  (cmp_ev[i]),
            .cap_ev  (cap_ev[i])
        );
    end

    tmr_clr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .code       (ctl_r[7:5]),
        .sync_en    (ctl_r[4]),
        .buf_c      (ctl_r[3]),
        .buf_d      (ctl_r[2]),
        .ev         (ev),
        .sync_clr_in(sync_clr_in),
        .own_clr    (own_clr),
        .follow_clr (follow_clr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count   <= '0;
            clr_out <= 1'b0;
            cmp_hit <= '0;
            cap_hit <= '0;
        end else begin
            if (cnt_wr)
                count <= wr_data;
            else if (own_clr || follow_clr)
                count <= '0;
            else if (adv)
                count <= count + 1'b1;
            clr_out <= own_clr && !cnt_wr;
            cmp_hit <= cmp_ev;
            cap_hit <= cap_ev;
        end
    end
endmodule

// File: rtl/tmr_clrsel_chk.sv
module tmr_clrsel_chk #(
    parameter int CNT_W    = 16,
    parameter bit FULL_CLR = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             wr_en,
    input logic [3:0]       cap_in,
    input logic             sync_clr_in,
    input logic [CNT_W-1:0] count,
    input logic [3:0]       cmp_hit,
    input logic [3:0]       cap_hit,
    input logic             clr_out,
    input logic [7:0]       ctl_q
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (count == '0 && !clr_out && ctl_q == 8'h00));

    a_r3_clrout_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_out |-> (count == '0));

    a_r6_buffer_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[3] |=> (!cmp_hit[2] && !cap_hit[2]));

    a_r7_follow_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_clr_in && ctl_q[4] && ctl_q[6:5] == 2'b11 && !wr_en && $stable(ctl_q))
        |=> (count == '0 && !clr_out));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !wr_en && !sync_clr_in && cap_in == 4'b0000)
        |=> (count == $past(count)));

    if (!FULL_CLR) begin : g_reduced
        a_r9_bit7_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !ctl_q[7]);
    end
endmodule

bind tmr_clrsel_chan tmr_clrsel_chk #(.CNT_W(CNT_W), .FULL_CLR(FULL_CLR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_en     (cnt_en),
    .wr_en      (wr_en),
    .cap_in     (cap_in),
    .sync_clr_in(sync_clr_in),
    .count      (count),
    .cmp_hit    (cmp_hit),
    .cap_hit    (cap_hit),
    .clr_out    (clr_out),
    .ctl_q      (ctl_q)
);

// File: tb/sim_tmr_clrsel_chan.sv
module sim_tmr_clrsel_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0, tick = 1'b0, wr_en = 1'b0, sync_clr_in = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  cap_in = '0;

    logic [15:0] count, u1_count;
    logic [3:0]  cmp_hit, cap_hit, u1_cmp, u1_cap;
    logic        clr_out, u1_clr;
    logic [7:0]  ctl_q, u1_ctl;
    logic [63:0] gr_flat, u1_gr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr_clrsel_chan #(.CNT_W(16), .FULL_CLR(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .cap_in(cap_in), .sync_clr_in(sync_clr_in),
        .count(count), .cmp_hit(cmp_hit), .cap_hit(cap_hit), .clr_out(clr_out),
        .ctl_q(ctl_q), .gr_flat(gr_flat));

    tmr_clrsel_chan #(.CNT_W(16), .FULL_CLR(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .cap_in(cap_in), .sync_clr_in(sync_clr_in),
        .count(u1_count), .cmp_hit(u1_cmp), .cap_hit(u1_cap), .clr_out(u1_clr),
        .ctl_q(u1_ctl), .gr_flat(u1_gr));

    typedef enum int {K_CNT, K_CLR, K_CMP, K_CAP, K_CTL, K_GR, K_U1CNT, K_U1CTL} kind_e;
    typedef struct {
        string       tag;
        kind_e       kind;
        int          idx;
        logic [15:0] exp;
    } exp_t;
    exp_t sb[$];

    function automatic logic [15:0] observe(kind_e k, int idx);
        case (k)
            K_CNT:   return count;
            K_CLR:   return {15'd0, clr_out};
            K_CMP:   return {12'd0, cmp_hit};
            K_CAP:   return {12'd0, cap_hit};
            K_CTL:   return {8'd0, ctl_q};
            K_GR:    return gr_flat[idx*16 +: 16];
            K_U1CNT: return u1_count;
            default: return {8'd0, u1_ctl};
        endcase
    endfunction

    task automatic want(string tag, kind_e k, int idx, logic [15:0] e);
        exp_t it;
        it.tag = tag; it.kind = k; it.idx = idx; it.exp = e;
        sb.push_back(it);
    endtask

    // monitor: compare queued expectations in the middle of the cycle
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t it;
            logic [15:0] got;
            it = sb.pop_front();
            got = observe(it.kind, it.idx);
            checks++;
            if (got !== it.exp) begin
                failures++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, got, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic run_on(input bit on);
        cnt_en = on; tick = on;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        // R1 reset state
        want("R1 count", K_CNT, 0, 16'd0);
        want("R1 ctl", K_CTL, 0, 16'h0000);
        want("R1 clr_out", K_CLR, 0, 16'd0);
        want("R1 cmp_hit", K_CMP, 0, 16'd0);
        want("R1 slot D reset", K_GR, 3, 16'hFFFF);
        step();

        // R2: code 000 does not clear on A match
        wr(3'd0, 16'd3);
        wr(3'd4, 16'h0000);
        wr(3'd5, 16'd0);
        run_on(1);
        for (int k = 1; k <= 5; k++) begin
            step();
            if (k == 4) begin
                want("R2 match flag code000", K_CMP, 0, 16'h0001);
                want("R2 no clr_out code000", K_CLR, 0, 16'd0);
            end
        end
        want("R2 count past match code000", K_CNT, 0, 16'd5);
        run_on(0);
        // R2: code 100 also disabled
        wr(3'd4, 16'h0080);
        wr(3'd5, 16'd0);
        run_on(1);
        repeat (5) step();
        want("R2 count past match code100", K_CNT, 0, 16'd5);
        run_on(0);

        // R10: no advance or match while cnt_en low; R3 clear on A
        wr(3'd4, 16'h0020);
        wr(3'd5, 16'd3);
        tick = 1'b1;
        repeat (3) step();
        want("R10 count held", K_CNT, 0, 16'd3);
        want("R10 no match when disabled", K_CMP, 0, 16'd0);
        cnt_en = 1'b1;
        step();
        want("R3 A match clears", K_CNT, 0, 16'd0);
        want("R3 clr_out on A clear", K_CLR, 0, 16'd1);
        step();
        want("R3 count resumes", K_CNT, 0, 16'd1);
        want("R3 clr_out one clock", K_CLR, 0, 16'd0);
        run_on(0);

        // R3: code 010 clears on B
        wr(3'd1, 16'd5);
        wr(3'd4, 16'h0040);
        wr(3'd5, 16'd4);
        run_on(1);
        step();
        want("R3 B count before", K_CNT, 0, 16'd5);
        step();
        want("R3 B match clears", K_CNT, 0, 16'd0);
        want("R3 B clr_out", K_CLR, 0, 16'd1);
        want("R3 B flag", K_CMP, 0, 16'h0002);
        run_on(0);

        // R4 code 101 clears on C; R9 reduced instance sees 001
        wr(3'd2, 16'd2);
        wr(3'd4, 16'h00A0);
        want("R9 full ctl keeps bit7", K_CTL, 0, 16'h00A0);
        want("R9 reduced ctl bit7 zero", K_U1CTL, 0, 16'h0020);
        wr(3'd5, 16'd0);
        run_on(1);
        repeat (3) step();
        want("R4 C match clears", K_CNT, 0, 16'd0);
        want("R4 C clr_out", K_CLR, 0, 16'd1);
        want("R9 reduced not cleared by C", K_U1CNT, 0, 16'd3);
        run_on(0);
        // R4 code 110 clears on D
        wr(3'd3, 16'd1);
        wr(3'd4, 16'h00C0);
        wr(3'd5, 16'd0);
        run_on(1);
        step();
        step();
        want("R4 D match clears", K_CNT, 0, 16'd0);
        want("R4 D flag", K_CMP, 0, 16'h0008);
        run_on(0);

        // R5 capture into selected B clears the counter
        wr(3'd6, 16'h0002);
        wr(3'd4, 16'h0040);
        wr(3'd5, 16'd0);
        run_on(1);
        repeat (4) step();
        want("R5 count before capture", K_CNT, 0, 16'd4);
        cap_in = 4'b0010;
        step();
        cap_in = 4'b0000;
        want("R5 captured value", K_GR, 1, 16'd4);
        want("R5 capture clears", K_CNT, 0, 16'd0);
        want("R5 clr_out on capture", K_CLR, 0, 16'd1);
        want("R5 cap flag", K_CAP, 0, 16'h0002);
        run_on(0);
        // R5 capture without clear
        wr(3'd4, 16'h0000);
        wr(3'd5, 16'd7);
        cap_in = 4'b0010;
        step();
        cap_in = 4'b0000;
        want("R5 capture no clear value", K_GR, 1, 16'd7);
        want("R5 capture no clear count", K_CNT, 0, 16'd7);
        want("R5 capture no clr_out", K_CLR, 0, 16'd0);

        // R6 slot C as buffer: no match, no clear, no capture
        wr(3'd6, 16'h0000);
        wr(3'd2, 16'd2);
        wr(3'd4, 16'h00A8);
        wr(3'd5, 16'd0);
        run_on(1);
        repeat (3) step();
        want("R6 no C match flag", K_CMP, 0, 16'd0);
        want("R6 no clear by buffered C", K_CNT, 0, 16'd3);
        repeat (2) step();
        want("R6 count keeps going", K_CNT, 0, 16'd5);
        run_on(0);
        wr(3'd6, 16'h0004);
        cap_in = 4'b0100;
        step();
        cap_in = 4'b0000;
        want("R6 buffered C keeps value", K_GR, 2, 16'd2);
        want("R6 no cap flag", K_CAP, 0, 16'd0);
        want("R6 count unchanged", K_CNT, 0, 16'd5);

        // R7 follow clear with codes 011 and 111
        wr(3'd6, 16'h0000);
        wr(3'd4, 16'h0070);
        wr(3'd5, 16'd9);
        sync_clr_in = 1'b1;
        step();
        sync_clr_in = 1'b0;
        want("R7 sync clear code011", K_CNT, 0, 16'd0);
        want("R7 no clr_out on follow", K_CLR, 0, 16'd0);
        wr(3'd4, 16'h00F0);
        wr(3'd5, 16'd9);
        sync_clr_in = 1'b1;
        step();
        sync_clr_in = 1'b0;
        want("R7 sync clear code111", K_CNT, 0, 16'd0);

        // R8 sync clear ignored
        wr(3'd4, 16'h0060);
        wr(3'd5, 16'd9);
        sync_clr_in = 1'b1;
        step();
        sync_clr_in = 1'b0;
        want("R8 ignored without sync enable", K_CNT, 0, 16'd9);
        wr(3'd4, 16'h0030);
        wr(3'd5, 16'd9);
        sync_clr_in = 1'b1;
        step();
        sync_clr_in = 1'b0;
        want("R8 ignored for code001", K_CNT, 0, 16'd9);

        step();
        step();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule